// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block sits between a clocked host and an external 128K x 8 asynchronous static RAM that shares one bidirectional data bus. The host hands over one byte access at a time through a ready/valid handshake: a 17-bit address, a write flag and, for writes, a data byte. Reads return a byte together with a one-cycle valid pulse.

On the memory side the controller drives the address, an active-low chip enable, an active-high chip select, an active-low write strobe, an active-low output enable, and the output-enable and output-value halves of a tri-state data pad. Every timing minimum is given in picoseconds as a parameter. Each one is rounded up to whole clock cycles. The strobe sequences are built from those cycle counts so that data is sampled only after the slowest applicable access path has settled. The address moves only while the device is deselected. The host never drives the bus while the memory may still be driving it. Between accesses the device sits deselected in standby with the pads released.

Top module: `sram_async_ctrl`

## Requirements
- R1: While reset is held and on its release, chip enable is high, chip select is low, write strobe and output enable are high, the data pad driver is off, ready is high and the read-valid pulse is low.
- R2: Whenever ready is high, the memory is deselected (chip enable high, chip select low) and the data pad driver is off.
- R3: A read holds chip enable low, chip select high, write strobe high and output enable low on a stable address for RD = max(ceil(tAA), ceil(tOE), ceil(tRC)) cycles. Output enable is low only in this state.
- R4: The read byte is captured at the end of the last read cycle. The read-valid pulse is high for exactly one cycle, RD+1 cycles after the accepting edge, and carries the byte last written to that address.
- R5: A write spends one cycle with chip enable low, write strobe high and data driven. It then holds the write strobe low for WP = max(ceil(tWP), ceil(tAW), ceil(tDS), ceil(tRC)-2) cycles, then spends one hold cycle with both strobes high and data still driven. Ready returns WP+3 cycles after the accepting edge.
- R6: Output enable stays high throughout every write. The data pad driver is on during every write-strobe-low cycle.
- R7: The memory address changes only on an accepting edge, while chip enable is high. It is never changed while chip enable and write strobe are both low.
- R8: After output enable rises, the data pad driver stays off for at least HZ = ceil(max(tOHZ, tWLZ)) cycles. A read returns ready RD+HZ+1 cycles after the accepting edge.
- R9: A request presented while ready is low is not taken: it changes no memory content.
- R10: A request is accepted on an edge where both valid and ready are high. Ready is low in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Controller idle and able to accept |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Byte address |
| req_wdata | input | 8 | Write data |
| rd_valid | output | 1 | One-cycle pulse with read data |
| rd_data | output | 8 | Captured read byte |
| mem_addr | output | 17 | Memory address pins |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_cs | output | 1 | Chip select, active high |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_dq_out | output | 8 | Value for the data pads |
| mem_dq_oe | output | 1 | Data pad driver enable |
| mem_dq_in | input | 8 | Value read from the data pads |

## Verification
The bench builds the controller with a 20000 ps clock and the default timing minimums. This gives a 4-cycle read window, a 3-cycle write pulse and a 2-cycle turnaround. Those windows are short enough that a read window one cycle too short returns wrong data from the bench memory model, which answers with the complement of the byte until the access time has passed. The same model flags any driver overlap inside the turnaround window. Addresses 0 and 0x1FFFF, a small reused pool and random full-range addresses are all exercised.

// File: rtl/sram_ctrl_pkg.sv
`timescale 1ns/1ps
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_ACC,
    ST_RD_HIZ,
    ST_WR_SETUP,
    ST_WR_PULSE,
    ST_WR_HOLD
  } seq_state_e;

  typedef struct packed {
    logic ce_n;
    logic cs;
    logic we_n;
    logic oe_n;
    logic dq_oe;
    logic ready;
  } pin_ctl_t;

  function automatic int ceil_cyc(input int t_ps, input int clk_ps);
    return (t_ps + clk_ps - 1) / clk_ps;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int calc_rd(input int clk_ps, input int t_aa, input int t_oe, input int t_rc);
    return max2(1, max2(max2(ceil_cyc(t_aa, clk_ps), ceil_cyc(t_oe, clk_ps)), ceil_cyc(t_rc, clk_ps)));
  endfunction

  function automatic int calc_wp(input int clk_ps, input int t_wp, input int t_aw,
                                 input int t_ds, input int t_rc);
    return max2(1, max2(max2(ceil_cyc(t_wp, clk_ps), ceil_cyc(t_aw, clk_ps)),
                        max2(ceil_cyc(t_ds, clk_ps), ceil_cyc(t_rc, clk_ps) - 2)));
  endfunction

  function automatic int calc_hz(input int clk_ps, input int t_ohz, input int t_whz);
    return max2(1, ceil_cyc(max2(t_ohz, t_whz), clk_ps));
  endfunction

  // Pin levels that belong to each sequencer state.
  function automatic pin_ctl_t decode_pins(input seq_state_e s);
    pin_ctl_t p;
    p = '{ce_n: 1'b1, cs: 1'b0, we_n: 1'b1, oe_n: 1'b1, dq_oe: 1'b0, ready: 1'b0};
    case (s)
      ST_IDLE:     p.ready = 1'b1;
      ST_RD_ACC:   begin p.ce_n = 1'b0; p.cs = 1'b1; p.oe_n = 1'b0; end
      ST_RD_HIZ:   ;
      ST_WR_SETUP: begin p.ce_n = 1'b0; p.cs = 1'b1; p.dq_oe = 1'b1; end
      ST_WR_PULSE: begin p.ce_n = 1'b0; p.cs = 1'b1; p.we_n = 1'b0; p.dq_oe = 1'b1; end
      ST_WR_HOLD:  p.dq_oe = 1'b1;
      default:     p.ready = 1'b1;
    endcase
    return p;
  endfunction

endpackage

// File: rtl/sram_cycle_timer.sv
`timescale 1ns/1ps
module sram_cycle_timer #(
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          done
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign done = (cnt_q == '0);

endmodule

// File: rtl/sram_seq_fsm.sv
`timescale 1ns/1ps
module sram_seq_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int RD_CYC = 7,
  parameter int WP_CYC = 6,
  parameter int HZ_CYC = 3,
  parameter int CW     = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic          tmr_done,
  output logic          tmr_load,
  output logic [CW-1:0] tmr_val,
  output logic          accept,
  output logic          capture,
  output seq_state_e    state_d
);

  seq_state_e state_q;

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    accept   = 1'b0;
    capture  = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          accept = 1'b1;
          if (req_write) begin
            state_d = ST_WR_SETUP;
          end else begin
            state_d  = ST_RD_ACC;
            tmr_load = 1'b1;
            tmr_val  = CW'(RD_CYC - 1);
          end
        end
      end
      ST_RD_ACC: begin
        if (tmr_done) begin
          capture  = 1'b1;
          state_d  = ST_RD_HIZ;
          tmr_load = 1'b1;
          tmr_val  = CW'(HZ_CYC - 1);
        end
      end
      ST_RD_HIZ: begin
        if (tmr_done) state_d = ST_IDLE;
      end
      ST_WR_SETUP: begin
        state_d  = ST_WR_PULSE;
        tmr_load = 1'b1;
        tmr_val  = CW'(WP_CYC - 1);
      end
      ST_WR_PULSE: begin
        if (tmr_done) state_d = ST_WR_HOLD;
      end
      ST_WR_HOLD: state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_IDLE;
    else     state_q <= state_d;
  end

endmodule

// File: rtl/sram_io_regs.sv
`timescale 1ns/1ps
module sram_io_regs
  import sram_ctrl_pkg::*;
#(
  parameter int AW = 17,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  seq_state_e    state_d,
  input  logic          accept,
  input  logic          capture,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic [DW-1:0] mem_dq_in,
  output pin_ctl_t      ctl,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_dq_out,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data
);

  // Strobes are registered from the next state so every pin leaves a flop.
  always_ff @(posedge clk) begin
    if (rst) begin
      ctl      <= decode_pins(ST_IDLE);
      rd_valid <= 1'b0;
    end else begin
      ctl      <= decode_pins(state_d);
      rd_valid <= capture;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_addr   <= '0;
      mem_dq_out <= '0;
      rd_data    <= '0;
    end else begin
      if (accept) begin
        mem_addr   <= req_addr;
        mem_dq_out <= req_wdata;
      end
      if (capture) rd_data <= mem_dq_in;
    end
  end

endmodule

// File: rtl/sram_async_ctrl.sv
`timescale 1ns/1ps
module sram_async_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W   = 17,
  parameter int DATA_W   = 8,
  parameter int CLK_PS   = 10000,
  parameter int T_AA_PS  = 70000,
  parameter int T_OE_PS  = 35000,
  parameter int T_RC_PS  = 70000,
  parameter int T_WP_PS  = 60000,
  parameter int T_AW_PS  = 60000,
  parameter int T_DS_PS  = 30000,
  parameter int T_OHZ_PS = 25000,
  parameter int T_WHZ_PS = 20000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_cs,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);

  localparam int RD_CYC = calc_rd(CLK_PS, T_AA_PS, T_OE_PS, T_RC_PS);
  localparam int WP_CYC = calc_wp(CLK_PS, T_WP_PS, T_AW_PS, T_DS_PS, T_RC_PS);
  localparam int HZ_CYC = calc_hz(CLK_PS, T_OHZ_PS, T_WHZ_PS);
  localparam int MAX_CYC = max2(RD_CYC, max2(WP_CYC, HZ_CYC));
  localparam int CW = $clog2(MAX_CYC + 1);

  logic          tmr_load;
  logic [CW-1:0] tmr_val;
  logic          tmr_done;
  logic          accept;
  logic          capture;
  seq_state_e    state_d;
  pin_ctl_t      ctl;

  sram_cycle_timer #(.CW(CW)) i_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .done     (tmr_done)
  );

  sram_seq_fsm #(
    .RD_CYC (RD_CYC),
    .WP_CYC (WP_CYC),
    .HZ_CYC (HZ_CYC),
    .CW     (CW)
  ) i_fsm (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_write (req_write),
    .tmr_done  (tmr_done),
    .tmr_load  (tmr_load),
    .tmr_val   (tmr_val),
    .accept    (accept),
    .capture   (capture),
    .state_d   (state_d)
  );

  sram_io_regs #(.AW(ADDR_W), .DW(DATA_W)) i_io (
    .clk        (clk),
    .rst        (rst),
    .state_d    (state_d),
    .accept     (accept),
    .capture    (capture),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .mem_dq_in  (mem_dq_in),
    .ctl        (ctl),
    .mem_addr   (mem_addr),
    .mem_dq_out (mem_dq_out),
    .rd_valid   (rd_valid),
    .rd_data    (rd_data)
  );

  assign req_ready = ctl.ready;
  assign mem_ce_n  = ctl.ce_n;
  assign mem_cs    = ctl.cs;
  assign mem_we_n  = ctl.we_n;
  assign mem_oe_n  = ctl.oe_n;
  assign mem_dq_oe = ctl.dq_oe;

endmodule

// File: rtl/sram_async_ctrl_chk.sv
`timescale 1ns/1ps
module sram_async_ctrl_chk
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W   = 17,
  parameter int CLK_PS   = 10000,
  parameter int T_RC_PS  = 70000,
  parameter int T_WP_PS  = 60000,
  parameter int T_AW_PS  = 60000,
  parameter int T_DS_PS  = 30000,
  parameter int T_OHZ_PS = 25000,
  parameter int T_WHZ_PS = 20000
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rd_valid,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_ce_n,
  input logic              mem_we_n,
  input logic              mem_oe_n,
  input logic              mem_dq_oe
);

  localparam int WP_CYC = calc_wp(CLK_PS, T_WP_PS, T_AW_PS, T_DS_PS, T_RC_PS);
  localparam int HZ_CYC = calc_hz(CLK_PS, T_OHZ_PS, T_WHZ_PS);
  localparam int GW = $clog2(HZ_CYC + 1);
  localparam int LW = $clog2(WP_CYC + 1);

  logic [GW-1:0] gap_q;
  logic [LW-1:0] wlow_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      gap_q  <= GW'(HZ_CYC);
      wlow_q <= '0;
    end else begin
      if (!mem_oe_n)               gap_q <= '0;
      else if (gap_q != GW'(HZ_CYC)) gap_q <= gap_q + 1'b1;
      if (mem_we_n)                 wlow_q <= '0;
      else if (wlow_q != LW'(WP_CYC)) wlow_q <= wlow_q + 1'b1;
    end
  end

  AST_IDLE_STANDBY: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (mem_ce_n && !mem_dq_oe)); // R2
  AST_RD_MODE_ONLY: assert property (@(posedge clk) disable iff (rst)
    !mem_oe_n |-> (!mem_ce_n && mem_we_n)); // R3
  AST_RDV_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    rd_valid |=> !rd_valid); // R4
  AST_WR_PULSE_WIDTH: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_we_n) |-> (wlow_q >= LW'(WP_CYC))); // R5
  AST_WR_OE_HIGH: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> (mem_oe_n && mem_dq_oe && !mem_ce_n)); // R6
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (rst)
    !mem_ce_n |=> (mem_ce_n || $stable(mem_addr))); // R7
  AST_TURNAROUND: assert property (@(posedge clk) disable iff (rst)
    mem_dq_oe |-> (mem_oe_n && gap_q >= GW'(HZ_CYC))); // R8
  AST_READY_DROP: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready); // R10

endmodule

bind sram_async_ctrl sram_async_ctrl_chk #(
  .ADDR_W   (ADDR_W),
  .CLK_PS   (CLK_PS),
  .T_RC_PS  (T_RC_PS),
  .T_WP_PS  (T_WP_PS),
  .T_AW_PS  (T_AW_PS),
  .T_DS_PS  (T_DS_PS),
  .T_OHZ_PS (T_OHZ_PS),
  .T_WHZ_PS (T_WHZ_PS)
) i_chk (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .rd_valid  (rd_valid),
  .mem_addr  (mem_addr),
  .mem_ce_n  (mem_ce_n),
  .mem_we_n  (mem_we_n),
  .mem_oe_n  (mem_oe_n),
  .mem_dq_oe (mem_dq_oe)
);

// File: tb/test_sram_async_ctrl.sv
`timescale 1ns/1ps
module test_sram_async_ctrl;

  localparam int CLK_PS = 20000;
  // Cycle counts derived here from the requirement formulas.
  localparam int NRD = 4;  // max(ceil(70/20)=4, ceil(35/20)=2, ceil(70/20)=4)
  localparam int NWP = 3;  // max(ceil(60/20)=3, 3, ceil(30/20)=2, 4-2=2)
  localparam int NHZ = 2;  // ceil(25/20)=2

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [16:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        rd_valid;
  logic [7:0]  rd_data;
  logic [16:0] mem_addr;
  logic        mem_ce_n, mem_cs, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [7:0]  mem_dq_out;
  logic [7:0]  dq_in_r = 8'hEE;

  int nchk = 0;
  int nfail = 0;

  always #10 clk = ~clk;

  sram_async_ctrl #(.CLK_PS(CLK_PS)) i_sram_async_ctrl (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_write  (req_write),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .rd_valid   (rd_valid),
    .rd_data    (rd_data),
    .mem_addr   (mem_addr),
    .mem_ce_n   (mem_ce_n),
    .mem_cs     (mem_cs),
    .mem_we_n   (mem_we_n),
    .mem_oe_n   (mem_oe_n),
    .mem_dq_out (mem_dq_out),
    .mem_dq_oe  (mem_dq_oe),
    .mem_dq_in  (dq_in_r)
  );

  // ---------------- behavioural memory model ----------------
  logic [7:0] dev_mem [int];
  logic [7:0] exp_mem [int];

  function automatic logic [7:0] init_val(input int a);
    return 8'((a * 37) ^ (a >>> 9) ^ 8'h5A);
  endfunction

  function automatic logic [7:0] dev_read(input int a);
    return dev_mem.exists(a) ? dev_mem[a] : init_val(a);
  endfunction

  function automatic logic [7:0] exp_read(input int a);
    return exp_mem.exists(a) ? exp_mem[a] : init_val(a);
  endfunction

  int   rd_age = 0;
  int   hz_cnt = 0;
  int   rd_a = 0;
  bit   prev_wr = 1'b0;
  int   wcnt = 0;
  int   wr_a = 0;
  logic [7:0] wr_d = '0;
  int   v_contention = 0;
  int   v_addr = 0;
  int   v_mode = 0;
  int   v_width = 0;

  always @(negedge clk) begin
    bit rd_mode, wr_mode;
    if (!rst) begin
      rd_mode = !mem_ce_n && mem_cs && mem_we_n && !mem_oe_n;
      wr_mode = !mem_ce_n && mem_cs && !mem_we_n;
      if (mem_dq_oe && (rd_mode || hz_cnt > 0)) v_contention++;
      if (!mem_ce_n && !mem_we_n && !mem_oe_n) v_mode++;
      if (wr_mode && !mem_dq_oe) v_mode++;
      if (rd_mode) begin
        if (rd_age > 0 && int'(mem_addr) == rd_a) rd_age++;
        else rd_age = 1;
        rd_a = int'(mem_addr);
        hz_cnt = NHZ;
        dq_in_r = (rd_age >= NRD) ? dev_read(rd_a) : ~dev_read(rd_a);
      end else begin
        rd_age = 0;
        if (hz_cnt > 0) hz_cnt--;
        dq_in_r = 8'hEE;
      end
      if (wr_mode) begin
        if (prev_wr && (int'(mem_addr) != wr_a || mem_dq_out != wr_d)) v_addr++;
        wcnt = prev_wr ? wcnt + 1 : 1;
        wr_a = int'(mem_addr);
        wr_d = mem_dq_out;
      end else if (prev_wr) begin
        if (wcnt < NWP) v_width++;
        dev_mem[wr_a] = wr_d;
      end
      prev_wr = wr_mode;
    end
  end

  // ---------------- checking helpers ----------------
  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic issue(input bit wr, input logic [16:0] a, input logic [7:0] d);
    int guard = 0;
    @(negedge clk);
    while (!req_ready && guard < 100) begin
      @(negedge clk);
      guard++;
    end
    chk(req_ready && mem_ce_n && !mem_cs && !mem_dq_oe, "R2 idle standby",
        {req_ready, mem_ce_n, mem_cs, mem_dq_oe}, 4'b1100);
    req_valid = 1'b1;
    req_write = wr;
    req_addr  = a;
    req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready, "R10 ready drops after accept", req_ready, 0);
  endtask

  task automatic do_write(input logic [16:0] a, input logic [7:0] d);
    int n;
    issue(1'b1, a, d);
    // cycle 1: setup
    chk(!mem_ce_n && mem_cs && mem_we_n && mem_dq_oe && mem_oe_n,
        "R5 setup cycle strobes", {mem_ce_n, mem_cs, mem_we_n, mem_dq_oe}, 4'b0111);
    chk(mem_addr == a && mem_dq_out == d, "R7 address/data presented",
        {mem_addr, mem_dq_out}, {a, d});
    n = 1;
    @(negedge clk);
    n++;
    chk(!mem_we_n && mem_oe_n, "R6 strobe low with output enable high",
        {mem_we_n, mem_oe_n}, 2'b01);
    while (!req_ready && n < 100) begin
      @(negedge clk);
      n++;
    end
    chk(n == NWP + 3, "R5 write occupancy", n, NWP + 3);
    exp_mem[int'(a)] = d;
  endtask

  task automatic do_read(input logic [16:0] a, input bit spur);
    int n;
    logic [7:0] e;
    e = exp_read(int'(a));
    issue(1'b0, a, 8'h00);
    chk(!mem_ce_n && mem_cs && mem_we_n && !mem_oe_n && !mem_dq_oe && mem_addr == a,
        "R3 read strobes", {mem_ce_n, mem_cs, mem_we_n, mem_oe_n}, 4'b0110);
    n = 1;
    if (spur) begin
      // R9: a write offered while busy must be ignored
      req_valid = 1'b1;
      req_write = 1'b1;
      req_addr  = a;
      req_wdata = ~e;
      @(negedge clk);
      n++;
      req_valid = 1'b0;
      req_write = 1'b0;
    end
    while (!rd_valid && n < 100) begin
      @(negedge clk);
      n++;
    end
    chk(n == NRD + 1, "R4 read latency", n, NRD + 1);
    chk(rd_data == e, spur ? "R9 ignored request left data" : "R4 read data", rd_data, e);
    @(negedge clk);
    n++;
    chk(!rd_valid && mem_oe_n && !mem_dq_oe, "R4 single pulse / R8 bus released",
        {rd_valid, mem_oe_n, mem_dq_oe}, 3'b010);
    while (!req_ready && n < 100) begin
      @(negedge clk);
      n++;
    end
    chk(n == NRD + NHZ + 1, "R8 read occupancy", n, NRD + NHZ + 1);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  // ---------------- stimulus ----------------
  initial begin
    logic [16:0] pool [8];
    void'($urandom(32'd20240607));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(mem_ce_n && !mem_cs && mem_we_n && mem_oe_n && !mem_dq_oe && req_ready && !rd_valid,
        "R1 reset pin state", {mem_ce_n, mem_cs, mem_we_n, mem_oe_n, mem_dq_oe, req_ready, rd_valid},
        7'b1011010);
    rst = 1'b0;
    @(negedge clk);
    chk(mem_ce_n && !mem_cs && !mem_dq_oe && req_ready && !rd_valid,
        "R1 state after release", {mem_ce_n, mem_cs, mem_dq_oe, req_ready}, 4'b1001);

    // directed corner cases
    do_read(17'h00000, 1'b0);             // never written: initial content
    do_write(17'h00000, 8'hA5);
    do_write(17'h1FFFF, 8'hFF);           // top address
    do_read(17'h1FFFF, 1'b0);             // R4 read after write
    do_write(17'h1FFFF, 8'h00);           // back-to-back writes (R7)
    do_write(17'h00001, 8'h3C);
    do_read(17'h1FFFF, 1'b0);
    do_read(17'h00000, 1'b0);
    do_write(17'h00002, 8'h81);           // write right after read (R8 turnaround)
    do_read(17'h00002, 1'b1);             // R9 spurious request while busy
    do_read(17'h00002, 1'b0);

    for (int i = 0; i < 8; i++) pool[i] = 17'($urandom);
    for (int i = 0; i < 80; i++) begin
      logic [16:0] a;
      a = ($urandom_range(0, 3) != 0) ? pool[$urandom_range(0, 7)] : 17'($urandom);
      if ($urandom_range(0, 1) == 1) do_write(a, 8'($urandom));
      else do_read(a, 1'b0);
    end

    chk(v_contention == 0, "R8 no bus contention seen by model", v_contention, 0);
    chk(v_addr == 0, "R7 address/data stable during write strobe", v_addr, 0);
    chk(v_mode == 0, "R6 legal mode combinations", v_mode, 0);
    chk(v_width == 0, "R5 write strobe width", v_width, 0);

    summary();
    $finish;
  end

endmodule